// File: doc/BRIEF.md
# Exclusive victim-fill L2 cache

This block is a small set-associative second-level cache. It holds tags and line data, and it sits between an upper-level cache and a memory port. It never holds a line that the upper level also holds. The only way to allocate an entry is an eviction from the upper level. A lookup that hits hands the line up together with its dirty status and frees the entry here. A lookup that misses is sent to memory as a line read, and the returned line goes straight upward without being kept.

The cache is write-back. When an insert needs a slot that holds a modified line, that line is written to memory first. A clean line in that slot is dropped with no memory traffic. The block handles one request at a time. When an insert and a lookup are offered together, the insert goes first, so the upper level can free its slot.

All data channels use valid/ready. A transfer happens on a rising edge where both valid and ready are high. A source that raises valid holds it, and its payload, steady until that transfer. The block follows this rule on its response and memory-request outputs. The insert channel's ready depends on the insert's target slot, so the upper level may see ready low for several cycles while a write-back is in progress. The memory side must accept write requests as complete at the request handshake, and must answer each read with exactly one response beat.

Top module: `l2x_victim_cache`

## Requirements
- R1: Reset invalidates every entry. After reset the response and memory-request valids are low, and every lookup misses.
- R2: An insert allocates the line with its data and dirty flag. A later lookup of that line answers with rsp_hit=1, the stored data and the stored dirty flag, and makes no memory request.
- R3: A lookup hit invalidates the entry, so a second lookup of the same line misses.
- R4: A lookup miss issues one memory read (mem_req_write=0) at the line address with the low log2(LINE_BYTES) address bits zero. The read data is returned with rsp_hit=0 and rsp_dirty=0, and no entry is allocated, so a repeat lookup misses again.
- R5: Displacing a clean line makes no memory request, and the insert is accepted without delay.
- R6: Displacing a dirty line first issues a memory write (mem_req_write=1) of that line's old address and data. vi_ready stays low until that write's handshake.
- R7: Within a set, an invalid way is always filled before any valid way is evicted. Among valid ways, the least recently inserted or rewritten way is evicted.
- R8: Inserting a line already present overwrites its data in place, ORs the new dirty flag into the stored one, and counts as the most recent use of that way.
- R9: At most one of vi_ready and lk_ready is high. While vi_valid is high, lk_ready is low.
- R10: While rsp_valid or mem_req_valid is high without its ready, the payload stays stable in the next cycle.
- R11: The set index is the low log2(SETS) bits of the line address, and the remaining upper bits are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_line | input | ADDR_W-log2(LINE_BYTES) | Line address to look up |
| vi_valid | input | 1 | Victim insert valid |
| vi_ready | output | 1 | Victim insert accepted |
| vi_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the victim |
| vi_data | input | 8*LINE_BYTES | Victim line data |
| vi_dirty | input | 1 | Victim is modified |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_ready | input | 1 | Upper level takes the answer |
| rsp_data | output | 8*LINE_BYTES | Returned line |
| rsp_dirty | output | 1 | Returned line is modified |
| rsp_hit | output | 1 | Line came from this cache |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write-back, 0 line read |
| mem_req_addr | output | ADDR_W | Line-aligned byte address |
| mem_req_wdata | output | 8*LINE_BYTES | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block takes the read data |
| mem_rsp_data | input | 8*LINE_BYTES | Read data |

## Verification
The checker's properties assume that the upper level keeps vi_valid and its payload steady until vi_ready. They also assume that memory returns read data only after it has accepted a read, and treats a write as finished at its request handshake. The bench drives every channel from tasks that raise valid after a clock edge and drop it only after a sampled handshake. Its memory model answers a read strictly after the request transfer, with a programmable acceptance latency. Under these conditions the write-back and hold properties describe only the block's own choices.

// File: rtl/l2x_pkg.sv
package l2x_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } l2x_state_e;
endpackage

// File: rtl/l2x_way_match.sv
module l2x_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 24,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  logic [TAG_W-1:0]           q_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = set_valid[w] && (set_tags[w] == q_tag);
  end

  always_comb begin
    hit     = |hv;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hv[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/l2x_lru.sv
module l2x_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int SET_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] sel_set,
  input  logic [WAYS-1:0]  set_valid,
  output logic [WAY_W-1:0] victim_way,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(WAYS - 1);

  // per-set age ranks: 0 is most recent, WAYS-1 is the eviction candidate
  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age[sel_set][w] == AGE_MAX) victim_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/l2x_victim_cache.sv
module l2x_victim_cache #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int WAYS       = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   lk_valid,
  output logic                                   lk_ready,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   lk_line,
  input  logic                                   vi_valid,
  output logic                                   vi_ready,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   vi_line,
  input  logic [8*LINE_BYTES-1:0]                vi_data,
  input  logic                                   vi_dirty,
  output logic                                   rsp_valid,
  input  logic                                   rsp_ready,
  output logic [8*LINE_BYTES-1:0]                rsp_data,
  output logic                                   rsp_dirty,
  output logic                                   rsp_hit,
  output logic                                   mem_req_valid,
  input  logic                                   mem_req_ready,
  output logic                                   mem_req_write,
  output logic [ADDR_W-1:0]                      mem_req_addr,
  output logic [8*LINE_BYTES-1:0]                mem_req_wdata,
  input  logic                                   mem_rsp_valid,
  output logic                                   mem_rsp_ready,
  input  logic [8*LINE_BYTES-1:0]                mem_rsp_data
);
  import l2x_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = LA_W - SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int ENT    = SETS * WAYS;
  localparam int ENT_W  = (ENT > 1) ? $clog2(ENT) : 1;

  function automatic logic [ENT_W-1:0] ent_of(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
    return ENT_W'(int'(s) * WAYS + int'(w));
  endfunction

  l2x_state_e state_q;

  logic [TAG_W-1:0]  tag_q  [ENT];
  logic [LINE_W-1:0] data_q [ENT];
  logic [ENT-1:0]    valid_q;
  logic [ENT-1:0]    dirty_q;

  logic [ENT_W-1:0]  wb_ent_q;
  logic [LA_W-1:0]   wb_line_q;
  logic [LA_W-1:0]   miss_line_q;
  logic [LINE_W-1:0] rsp_data_q;
  logic              rsp_dirty_q;
  logic              rsp_hit_q;

  // request under decision in the idle state: an insert wins over a lookup
  logic [LA_W-1:0]  q_line;
  logic [SET_W-1:0] q_set;
  logic [TAG_W-1:0] q_tag;

  assign q_line = vi_valid ? vi_line : lk_line;
  assign q_set  = q_line[SET_W-1:0];
  assign q_tag  = q_line[LA_W-1:SET_W];

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_set_view
    assign set_tags[w]  = tag_q[ent_of(q_set, WAY_W'(w))];
    assign set_valid[w] = valid_q[ent_of(q_set, WAY_W'(w))];
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] vic_way;

  l2x_way_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_match (
    .set_tags (set_tags),
    .set_valid(set_valid),
    .q_tag    (q_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  logic             idle;
  logic [WAY_W-1:0] ins_way;
  logic [ENT_W-1:0] ins_ent;
  logic [ENT_W-1:0] hit_ent;
  logic             slot_busy;
  logic             vi_fire;

  assign idle      = (state_q == ST_IDLE);
  assign ins_way   = hit ? hit_way : vic_way;
  assign ins_ent   = ent_of(q_set, ins_way);
  assign hit_ent   = ent_of(q_set, hit_way);
  assign slot_busy = !hit && valid_q[ins_ent] && dirty_q[ins_ent];

  assign vi_ready  = idle && vi_valid && !slot_busy;
  assign lk_ready  = idle && !vi_valid;
  assign vi_fire   = vi_valid && vi_ready;

  l2x_lru #(
    .SETS (SETS),
    .WAYS (WAYS),
    .SET_W(SET_W),
    .WAY_W(WAY_W)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_set   (q_set),
    .set_valid (set_valid),
    .victim_way(vic_way),
    .touch_en  (vi_fire),
    .touch_set (q_set),
    .touch_way (ins_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      valid_q     <= '0;
      dirty_q     <= '0;
      wb_ent_q    <= '0;
      wb_line_q   <= '0;
      miss_line_q <= '0;
      rsp_data_q  <= '0;
      rsp_dirty_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (vi_valid) begin
            if (!slot_busy) begin
              valid_q[ins_ent] <= 1'b1;
              dirty_q[ins_ent] <= vi_dirty | (hit & dirty_q[ins_ent]);
            end else begin
              wb_ent_q  <= ins_ent;
              wb_line_q <= {tag_q[ins_ent], q_set};
              state_q   <= ST_WBACK;
            end
          end else if (lk_valid) begin
            if (hit) begin
              rsp_data_q       <= data_q[hit_ent];
              rsp_dirty_q      <= dirty_q[hit_ent];
              rsp_hit_q        <= 1'b1;
              valid_q[hit_ent] <= 1'b0;
              dirty_q[hit_ent] <= 1'b0;
              state_q          <= ST_RESP;
            end else begin
              miss_line_q <= q_line;
              state_q     <= ST_MREQ;
            end
          end
        end
        ST_WBACK: begin
          if (mem_req_ready) begin
            valid_q[wb_ent_q] <= 1'b0;
            dirty_q[wb_ent_q] <= 1'b0;
            state_q           <= ST_IDLE;
          end
        end
        ST_MREQ: begin
          if (mem_req_ready) state_q <= ST_MWAIT;
        end
        ST_MWAIT: begin
          if (mem_rsp_valid) begin
            rsp_data_q  <= mem_rsp_data;
            rsp_dirty_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            state_q     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (vi_fire) begin
      tag_q[ins_ent]  <= q_tag;
      data_q[ins_ent] <= vi_data;
    end
  end

  assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_MREQ);
  assign mem_req_write = (state_q == ST_WBACK);
  assign mem_req_addr  = {((state_q == ST_WBACK) ? wb_line_q : miss_line_q), {OFF_W{1'b0}}};
  assign mem_req_wdata = data_q[wb_ent_q];
  assign mem_rsp_ready = (state_q == ST_MWAIT);

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = rsp_data_q;
  assign rsp_dirty = rsp_dirty_q;
  assign rsp_hit   = rsp_hit_q;
endmodule

// File: rtl/l2x_checker.sv
module l2x_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_valid,
  input logic                      lk_ready,
  input logic                      vi_valid,
  input logic                      vi_ready,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [8*LINE_BYTES-1:0]   rsp_data,
  input logic                      rsp_dirty,
  input logic                      rsp_hit,
  input logic                      mem_req_valid,
  input logic                      mem_req_ready,
  input logic                      mem_req_write,
  input logic [ADDR_W-1:0]         mem_req_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R9: a single request is taken at a time
  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vi_ready && lk_ready));

  // R9: a pending insert blocks the lookup channel
  p_insert_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vi_valid |-> !lk_ready);

  // R10: response payload held until taken
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_dirty) && $stable(rsp_hit)));

  // R10: memory request held until accepted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)));

  // R6: a write-back only runs while an insert is held back
  p_wb_stalls_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (vi_valid && !vi_ready));

  // R4: an accepted lookup answers at once or goes to memory as a read
  p_lookup_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (rsp_valid || (mem_req_valid && !mem_req_write)));

  // R4: memory addresses are line aligned
  p_req_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));
endmodule

bind l2x_victim_cache l2x_checker #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES)
) i_l2x_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .vi_valid     (vi_valid),
  .vi_ready     (vi_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_dirty    (rsp_dirty),
  .rsp_hit      (rsp_hit),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr)
);

// File: tb/test_l2x_victim_cache.sv
module test_l2x_victim_cache;
  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 64;
  localparam int LINE_W     = 512;
  localparam int LA_W       = 26;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              lk_valid, lk_ready;
  logic [LA_W-1:0]   lk_line;
  logic              vi_valid, vi_ready;
  logic [LA_W-1:0]   vi_line;
  logic [LINE_W-1:0] vi_data;
  logic              vi_dirty;
  logic              rsp_valid, rsp_ready;
  logic [LINE_W-1:0] rsp_data;
  logic              rsp_dirty, rsp_hit;
  logic              mem_req_valid, mem_req_ready, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [LINE_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid, mem_rsp_ready;
  logic [LINE_W-1:0] mem_rsp_data;

  l2x_victim_cache i_l2x_victim_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_line(lk_line),
    .vi_valid(vi_valid), .vi_ready(vi_ready), .vi_line(vi_line),
    .vi_data(vi_data), .vi_dirty(vi_dirty),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_dirty(rsp_dirty), .rsp_hit(rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int wr_count = 0;
  int rd_count = 0;
  int mem_lat  = 1;
  int stall    = 0;
  int rsp_bad  = 0;
  logic [ADDR_W-1:0] last_wr_addr = '0;
  logic [ADDR_W-1:0] last_rd_addr = '0;
  logic [LINE_W-1:0] last_wr_data = '0;

  function automatic logic [LINE_W-1:0] pat(logic [LA_W-1:0] l, logic [31:0] salt);
    logic [31:0] x;
    x = ({6'b0, l} * 32'h0100_0193) ^ salt;
    return {16{x}};
  endfunction

  function automatic logic [LINE_W-1:0] mpat(logic [LA_W-1:0] l);
    return pat(l, 32'h5A5A_C3C3);
  endfunction

  // line address from tag and set; set is the low 2 bits (R11)
  function automatic logic [LA_W-1:0] ln(int tag, int set);
    return LA_W'(tag * 4 + set);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // memory model: programmable accept latency, one read beat per read
  initial begin
    bit req_fire = 0;
    bit rsp_fire = 0;
    bit rd_pend  = 0;
    logic [ADDR_W-1:0] rd_addr = '0;
    int lat = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rsp_fire) begin
        mem_rsp_valid = 1'b0;
        rsp_fire = 0;
      end
      if (rd_pend && !mem_rsp_valid) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mpat(rd_addr[ADDR_W-1:6]);
        rd_pend = 0;
      end
      if (mem_rsp_valid && mem_rsp_ready) rsp_fire = 1;
      if (req_fire) begin
        mem_req_ready = 1'b0;
        req_fire = 0;
        lat = mem_lat;
      end else if (mem_req_valid) begin
        if (lat > 0) lat--;
        else begin
          mem_req_ready = 1'b1;
          req_fire = 1;
          if (mem_req_write) begin
            wr_count++;
            last_wr_addr = mem_req_addr;
            last_wr_data = mem_req_wdata;
          end else begin
            rd_count++;
            last_rd_addr = mem_req_addr;
            rd_addr = mem_req_addr;
            rd_pend = 1;
          end
        end
      end else begin
        lat = mem_lat;
      end
    end
  end

  task automatic ins(input logic [LA_W-1:0] l, input logic [LINE_W-1:0] d, input bit dty);
    @(posedge clk); #1;
    vi_valid = 1'b1; vi_line = l; vi_data = d; vi_dirty = dty;
    stall = 0;
    do begin
      @(negedge clk);
      if (!vi_ready) stall++;
    end while (!vi_ready);
    @(posedge clk); #1;
    vi_valid = 1'b0;
  endtask

  task automatic take_rsp(input int hold, output logic [LINE_W-1:0] d, output bit dty, output bit h);
    do @(negedge clk); while (!rsp_valid);
    d = rsp_data; dty = rsp_dirty; h = rsp_hit;
    rsp_bad = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data != d || rsp_hit != h || rsp_dirty != dty) rsp_bad++;
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  task automatic look(input logic [LA_W-1:0] l, input int hold,
                      output logic [LINE_W-1:0] d, output bit dty, output bit h);
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_line = l;
    do @(negedge clk); while (!lk_ready);
    @(posedge clk); #1;
    lk_valid = 1'b0;
    take_rsp(hold, d, dty, h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] d;
    bit dty, h;
    int w0, r0;
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_line = '0;
    vi_valid = 1'b0; vi_line = '0; vi_data = '0; vi_dirty = 1'b0;
    rsp_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 64'(mem_req_valid), 0);
    chk(lk_ready == 1'b1 && vi_ready == 1'b0, "R1 ready state after reset",
        64'({lk_ready, vi_ready}), 64'b10);

    // R1 R4 R11: every set misses after reset, memory read at aligned address
    for (int s = 0; s < 4; s++) begin
      r0 = rd_count;
      look(ln(7, s), 0, d, dty, h);
      chk(h == 1'b0 && dty == 1'b0, "R1 miss after reset", 64'({h, dty}), 0);
      chk(d == mpat(ln(7, s)), "R4 miss data", d[63:0], mpat(ln(7, s)) [63:0]);
      chk(rd_count == r0 + 1 && last_rd_addr == {ln(7, s), 6'b0}, "R11 read address",
          64'(last_rd_addr), 64'({ln(7, s), 6'b0}));
    end

    // R2 R3 R11: fill every way of every set, hit once, then miss
    w0 = wr_count;
    for (int s = 0; s < 4; s++)
      for (int t = 1; t <= 2; t++)
        ins(ln(t, s), pat(ln(t, s), 32'(s)), bit'((s + t) % 2));
    for (int s = 0; s < 4; s++)
      for (int t = 1; t <= 2; t++) begin
        r0 = rd_count;
        look(ln(t, s), (s == 0 && t == 1) ? 3 : 0, d, dty, h);
        chk(h == 1'b1, "R2 hit flag", 64'(h), 1);
        chk(d == pat(ln(t, s), 32'(s)), "R2 hit data", d[63:0], pat(ln(t, s), 32'(s)) [63:0]);
        chk(dty == bit'((s + t) % 2), "R2 dirty travels up", 64'(dty), 64'((s + t) % 2));
        chk(rd_count == r0, "R2 no memory read on hit", 64'(rd_count), 64'(r0));
        if (s == 0 && t == 1) chk(rsp_bad == 0, "R10 response held", 64'(rsp_bad), 0);
      end
    for (int s = 0; s < 4; s++)
      for (int t = 1; t <= 2; t++) begin
        look(ln(t, s), 0, d, dty, h);
        chk(h == 1'b0 && d == mpat(ln(t, s)), "R3 entry freed by hit", 64'(h), 0);
      end
    chk(wr_count == w0, "R2 no write-back while filling", 64'(wr_count), 64'(w0));

    // R4: miss is not allocated
    look(ln(40, 1), 0, d, dty, h);
    look(ln(40, 1), 0, d, dty, h);
    chk(h == 1'b0, "R4 miss not allocated", 64'(h), 0);

    // R5 R7: clean LRU displacement in set 0
    w0 = wr_count;
    ins(ln(1, 0), pat(ln(1, 0), 1), 1'b0);
    ins(ln(2, 0), pat(ln(2, 0), 1), 1'b0);
    ins(ln(3, 0), pat(ln(3, 0), 1), 1'b0);
    chk(stall == 0, "R5 clean displacement accepted at once", 64'(stall), 0);
    chk(wr_count == w0, "R5 clean line dropped", 64'(wr_count), 64'(w0));
    look(ln(1, 0), 0, d, dty, h);
    chk(h == 1'b0, "R7 oldest way evicted", 64'(h), 0);
    look(ln(2, 0), 0, d, dty, h);
    chk(h == 1'b1, "R7 newer way kept", 64'(h), 1);
    look(ln(3, 0), 0, d, dty, h);
    chk(h == 1'b1 && d == pat(ln(3, 0), 1), "R7 new line stored", 64'(h), 1);

    // R8 R7: rewrite refreshes order in set 1
    ins(ln(1, 1), pat(ln(1, 1), 2), 1'b0);
    ins(ln(2, 1), pat(ln(2, 1), 2), 1'b0);
    ins(ln(1, 1), pat(ln(1, 1), 3), 1'b0);
    ins(ln(3, 1), pat(ln(3, 1), 2), 1'b0);
    look(ln(2, 1), 0, d, dty, h);
    chk(h == 1'b0, "R8 rewrite counts as use", 64'(h), 0);
    look(ln(1, 1), 0, d, dty, h);
    chk(h == 1'b1 && d == pat(ln(1, 1), 3), "R8 data overwritten in place", d[63:0], pat(ln(1, 1), 3) [63:0]);
    look(ln(3, 1), 0, d, dty, h);
    chk(h == 1'b1, "R7 line after rewrite kept", 64'(h), 1);

    // R8: dirty flags are ORed
    ins(ln(1, 2), pat(ln(1, 2), 4), 1'b1);
    ins(ln(1, 2), pat(ln(1, 2), 5), 1'b0);
    look(ln(1, 2), 0, d, dty, h);
    chk(h == 1'b1 && dty == 1'b1, "R8 dirty OR", 64'({h, dty}), 64'b11);
    chk(d == pat(ln(1, 2), 5), "R8 newest data", d[63:0], pat(ln(1, 2), 5) [63:0]);

    // R7: invalid way preferred over the oldest valid way in set 2
    ins(ln(4, 2), pat(ln(4, 2), 6), 1'b0);
    ins(ln(5, 2), pat(ln(5, 2), 6), 1'b0);
    look(ln(5, 2), 0, d, dty, h);
    ins(ln(6, 2), pat(ln(6, 2), 6), 1'b0);
    look(ln(4, 2), 0, d, dty, h);
    chk(h == 1'b1 && d == pat(ln(4, 2), 6), "R7 invalid way filled first", 64'(h), 1);
    look(ln(6, 2), 0, d, dty, h);
    chk(h == 1'b1, "R7 new line in freed way", 64'(h), 1);

    // R6: dirty displacement in set 3 with slow memory
    mem_lat = 3;
    ins(ln(1, 3), pat(ln(1, 3), 7), 1'b1);
    ins(ln(2, 3), pat(ln(2, 3), 7), 1'b0);
    w0 = wr_count;
    ins(ln(3, 3), pat(ln(3, 3), 7), 1'b0);
    chk(wr_count == w0 + 1, "R6 one write-back", 64'(wr_count), 64'(w0 + 1));
    chk(last_wr_addr == {ln(1, 3), 6'b0}, "R6 write-back address", 64'(last_wr_addr), 64'({ln(1, 3), 6'b0}));
    chk(last_wr_data == pat(ln(1, 3), 7), "R6 write-back data", last_wr_data[63:0], pat(ln(1, 3), 7) [63:0]);
    chk(stall >= mem_lat, "R6 insert held during write-back", 64'(stall), 64'(mem_lat));
    look(ln(1, 3), 0, d, dty, h);
    chk(h == 1'b0, "R6 written-back line gone", 64'(h), 0);
    look(ln(2, 3), 0, d, dty, h);
    chk(h == 1'b1, "R6 clean line kept", 64'(h), 1);
    look(ln(3, 3), 0, d, dty, h);
    chk(h == 1'b1 && d == pat(ln(3, 3), 7), "R6 inserted after write-back", 64'(h), 1);
    mem_lat = 1;

    // R9: simultaneous insert and lookup of the same line
    @(posedge clk); #1;
    vi_valid = 1'b1; vi_line = ln(9, 0); vi_data = pat(ln(9, 0), 8); vi_dirty = 1'b1;
    lk_valid = 1'b1; lk_line = ln(9, 0);
    @(negedge clk);
    chk(vi_ready == 1'b1 && lk_ready == 1'b0, "R9 insert wins arbitration",
        64'({vi_ready, lk_ready}), 64'b10);
    @(posedge clk); #1;
    vi_valid = 1'b0;
    do @(negedge clk); while (!lk_ready);
    @(posedge clk); #1;
    lk_valid = 1'b0;
    take_rsp(0, d, dty, h);
    chk(h == 1'b1 && dty == 1'b1 && d == pat(ln(9, 0), 8), "R9 lookup sees the insert",
        64'({h, dty}), 64'b11);

    summary();
    $finish;
  end
endmodule